// File: doc/BRIEF.md
# Idle Mode Wakeup Controller

This block stops and restarts the processor core clock around a low-power idle state. The always-on clock keeps running throughout, and so do the PLL, the timers, the interrupt logic and the peripherals, so a wakeup only has to reopen the core clock gate. The core asks for idle with a single-cycle wait-for-interrupt strobe. The block accepts it only after software has turned clock switching off. Clock switching is a bit that this block holds and that software sets and clears through two strobes.

While the core is idle, the block watches three things: the enabled pending interrupt sources, synchronised to the always-on clock; the mask register, where a set bit means unmasked; and a watchdog match. A mask-participation control bit chooses the wake rule. With the bit clear, any pending source wakes the core whether it is masked or not. With the bit set, only unmasked sources wake it. When the core wakes, the block reopens the gate, sends a one-cycle completion pulse for the pending wait, and records a wake cause. From that cause the core decides whether to resume in line (masked) or to take the interrupt (unmasked). The block reset also ends idle.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en` is 1, `idle` is 0, `clksw_en` is 1, `wfi_err` is 0, `wfi_done` is 0, and `wake_cause` is 3 (reset).
- R2: A `wfi_req` while `clksw_en` is 1 leaves the core running. One cycle later it sets `wfi_err`, which holds until an `err_clr` strobe clears it.
- R3: `clksw_off` clears `clksw_en` and `clksw_on` sets it. Both are ignored while idle, so `clksw_en` is still 0 after any wakeup.
- R4: A `wfi_req` while `clksw_en` is 0 and nothing qualifies makes `idle` 1 and `cpu_clk_en` 0 on the next cycle, and sets `wake_cause` to 0 (none).
- R5: With `dim` at 0, any pending source wakes the core, whatever its mask bit. The cause is 2 (unmasked) if some pending source has its `irq_unmask` bit set, and 1 (masked) otherwise.
- R6: With `dim` at 1, a pending source whose `irq_unmask` bit is 0 does not wake the core. A pending source whose bit is 1 does wake it, with cause 2.
- R7: A change on `irq_pend` or `wdog_match` takes effect on the third rising clock edge after it. On that edge `idle` falls, `cpu_clk_en` rises, and `wfi_done` is high for exactly that one cycle.
- R8: A watchdog match wakes the core with cause 4 (watchdog). This cause wins over any interrupt that qualifies at the same time.
- R9: If a source already qualifies when `wfi_req` arrives, `wfi_done` pulses on the next cycle and the clock is never gated. The cause follows R5, R6 and R8.
- R10: `cpu_gclk` is `clk` gated by the enable captured at the falling edge of `clk`. It stays low through every whole clock period of idle.
- R11: Asserting `rst_n` during idle ends idle at once. `cpu_clk_en` returns to 1 and the cause becomes 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset; also ends idle |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| clksw_off | input | 1 | Strobe that disables clock switching |
| clksw_on | input | 1 | Strobe that re-enables clock switching |
| err_clr | input | 1 | Clears the sticky request-error flag |
| dim | input | 1 | 1: mask register takes part in wakeup |
| irq_pend | input | N_IRQ | Enabled pending interrupt sources (asynchronous) |
| irq_unmask | input | N_IRQ | Mask register, 1 = unmasked |
| wdog_match | input | 1 | Watchdog match (asynchronous) |
| cpu_clk_en | output | 1 | Core clock enable |
| cpu_gclk | output | 1 | Glitch-free gated core clock |
| idle | output | 1 | Core is in idle |
| wfi_done | output | 1 | One-cycle completion of the pending wait |
| wake_cause | output | 3 | 0 none, 1 masked, 2 unmasked, 3 reset, 4 watchdog |
| clksw_en | output | 1 | Clock switching enabled |
| wfi_err | output | 1 | Sticky flag: request made while switching enabled |

## Verification
A wrong state bit shows up quickly. If the idle flag is stuck, the clock enable disagrees within one cycle of a request. If the wake rule is corrupted, either the idle period lasts longer than the fixed three-edge wake latency, or the wrong cause code appears alongside the completion pulse. The bench times every wake against that latency and compares each completion with a scoreboard of expected causes. Sampling the gated clock inside the high phase exposes an enable that changes at the wrong edge.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_MASKED   = 3'd1,
    CAUSE_UNMASKED = 3'd2,
    CAUSE_RESET    = 3'd3,
    CAUSE_WDOG     = 3'd4
  } wake_cause_e;
endpackage

// File: rtl/iwc_sync.sv
module iwc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/iwc_wake_eval.sv
module iwc_wake_eval
  import iwc_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] unmask,
  input  logic             dim,
  input  logic             wdog,
  output logic             wake_hit,
  output wake_cause_e      wake_kind
);
  // Sources allowed to end idle under the current mask rule
  function automatic logic [N_IRQ-1:0] qualify(input logic [N_IRQ-1:0] p,
                                               input logic [N_IRQ-1:0] m,
                                               input logic             use_mask);
    return use_mask ? (p & m) : p;
  endfunction

  function automatic wake_cause_e classify(input logic [N_IRQ-1:0] q,
                                           input logic [N_IRQ-1:0] m,
                                           input logic             wd);
    if (wd)           return CAUSE_WDOG;
    else if (|(q & m)) return CAUSE_UNMASKED;
    else if (|q)       return CAUSE_MASKED;
    else               return CAUSE_NONE;
  endfunction

  logic [N_IRQ-1:0] qual_vec;

  always_comb begin
    qual_vec  = qualify(pend, unmask, dim);
    wake_hit  = wdog | (|qual_vec);
    wake_kind = classify(qual_vec, unmask, wdog);
  end
endmodule

// File: rtl/iwc_clk_gate.sv
module iwc_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // Enable captured while clk is low so the AND never chops a high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lat <= 1'b1;
    else        en_lat <= en;
  end

  assign gclk = clk & en_lat;

  AST_GATE_EN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    en_lat == en); // R10
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import iwc_pkg::*;
#(
  parameter int N_IRQ       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             clksw_off,
  input  logic             clksw_on,
  input  logic             err_clr,
  input  logic             dim,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_unmask,
  input  logic             wdog_match,
  output logic             cpu_clk_en,
  output logic             cpu_gclk,
  output logic             idle,
  output logic             wfi_done,
  output logic [2:0]       wake_cause,
  output logic             clksw_en,
  output logic             wfi_err
);
  localparam int SW = N_IRQ + 1;

  logic [SW-1:0]    sync_out;
  logic [N_IRQ-1:0] pend_s;
  logic             wdog_s;
  logic             wake_hit;
  wake_cause_e      wake_kind;

  logic        idle_q, clksw_en_q, err_q, done_q;
  wake_cause_e cause_q;

  iwc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({wdog_match, irq_pend}),
    .q   (sync_out)
  );

  assign pend_s = sync_out[N_IRQ-1:0];
  assign wdog_s = sync_out[N_IRQ];

  iwc_wake_eval #(.N_IRQ(N_IRQ)) u_eval (
    .pend      (pend_s),
    .unmask    (irq_unmask),
    .dim       (dim),
    .wdog      (wdog_s),
    .wake_hit  (wake_hit),
    .wake_kind (wake_kind)
  );

  // Named events for the assertions
  logic wfi_accept, wfi_reject, wake_now;
  assign wfi_accept = !idle_q && wfi_req && !clksw_en_q;
  assign wfi_reject = !idle_q && wfi_req && clksw_en_q;
  assign wake_now   = idle_q && wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q     <= 1'b0;
      clksw_en_q <= 1'b1;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      cause_q    <= CAUSE_RESET;
    end else begin
      done_q <= 1'b0;
      if (!idle_q) begin
        if (clksw_off)     clksw_en_q <= 1'b0;
        else if (clksw_on) clksw_en_q <= 1'b1;
      end
      if (wfi_reject)   err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (wfi_accept) begin
        if (wake_hit) begin
          done_q  <= 1'b1;
          cause_q <= wake_kind;
        end else begin
          idle_q  <= 1'b1;
          cause_q <= CAUSE_NONE;
        end
      end else if (wake_now) begin
        idle_q  <= 1'b0;
        done_q  <= 1'b1;
        cause_q <= wake_kind;
      end
    end
  end

  iwc_clk_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cpu_clk_en),
    .gclk  (cpu_gclk)
  );

  assign cpu_clk_en = !idle_q;
  assign idle       = idle_q;
  assign wfi_done   = done_q;
  assign wake_cause = cause_q;
  assign clksw_en   = clksw_en_q;
  assign wfi_err    = err_q;

  AST_ENTRY_NEEDS_SW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> !$past(clksw_en_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R2
  AST_SW_OFF_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_q) |-> !clksw_en_q); // R3
  AST_EXIT_PULSES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_q) |-> done_q); // R7
  AST_DIM_NO_MASKED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (dim && wake_hit) |-> (wake_kind != CAUSE_MASKED)); // R6
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cause_q != CAUSE_NONE && cause_q != CAUSE_RESET)); // R5
  AST_WDOG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_now && wdog_s) |=> (cause_q == CAUSE_WDOG)); // R8
endmodule

// File: tb/tb_idle_wake_ctrl.sv
module tb_idle_wake_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, clksw_off = 0, clksw_on = 0, err_clr = 0, dim = 0, wdog_match = 0;
  logic [N-1:0] irq_pend = '0, irq_unmask = '0;
  logic cpu_clk_en, cpu_gclk, idle, wfi_done, clksw_en, wfi_err;
  logic [2:0] wake_cause;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  idle_wake_ctrl #(.N_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .clksw_off(clksw_off),
    .clksw_on(clksw_on), .err_clr(err_clr), .dim(dim), .irq_pend(irq_pend),
    .irq_unmask(irq_unmask), .wdog_match(wdog_match), .cpu_clk_en(cpu_clk_en),
    .cpu_gclk(cpu_gclk), .idle(idle), .wfi_done(wfi_done), .wake_cause(wake_cause),
    .clksw_en(clksw_en), .wfi_err(wfi_err)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every completion pulse must match the next expected cause
  always @(negedge clk) begin
    if (rst_n && wfi_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 got unexpected done cause %0d exp none", wake_cause);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(wake_cause) != e) begin
          errors++;
          $display("FAIL R5 wake cause got %0d exp %0d", wake_cause, e);
        end
      end
    end
  end

  task automatic enter_idle();
    wfi_req = 1; step(1); wfi_req = 0;
    chk("R4 idle", idle, 1);
    chk("R4 clk_en", cpu_clk_en, 0);
    chk("R4 cause none", wake_cause, 0);
  endtask

  task automatic wake_irq(input logic [N-1:0] p, input int exp_cause, input string req);
    exp_q.push_back(exp_cause);
    irq_pend = p;
    step(2);
    chk({req, " R7 still idle at edge 2"}, idle, 1);
    step(1);
    chk({req, " R7 clk_en at edge 3"}, cpu_clk_en, 1);
    chk({req, " R7 done pulse"}, wfi_done, 1);
    chk({req, " R3 clksw stays off"}, clksw_en, 0);
    step(1);
    chk("R7 done one cycle", wfi_done, 0);
    irq_pend = '0;
    step(3);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog got timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 clk_en", cpu_clk_en, 1);
    chk("R1 idle", idle, 0);
    chk("R1 clksw_en", clksw_en, 1);
    chk("R1 err", wfi_err, 0);
    chk("R1 done", wfi_done, 0);
    chk("R1 cause", wake_cause, 3);

    // R2: request while switching enabled
    wfi_req = 1; step(1); wfi_req = 0;
    chk("R2 no idle", idle, 0);
    chk("R2 clk_en kept", cpu_clk_en, 1);
    chk("R2 err set", wfi_err, 1);
    step(3);
    chk("R2 err sticky", wfi_err, 1);
    err_clr = 1; step(1); err_clr = 0;
    chk("R2 err cleared", wfi_err, 0);

    // R3: disable switching
    clksw_off = 1; step(1); clksw_off = 0;
    chk("R3 clksw off", clksw_en, 0);

    // R4 + R10
    enter_idle();
    @(posedge clk); #1;
    chk("R10 gclk low in idle", cpu_gclk, 0);
    step(1);
    // R5 masked wake, dim=0
    wake_irq(32'h0000_0008, 1, "R5 masked");
    @(posedge clk); #1;
    chk("R10 gclk high in run", cpu_gclk, 1);
    step(1);

    // R5 unmasked wake, dim=0
    irq_unmask = 32'h0000_0020;
    enter_idle();
    wake_irq(32'h0000_0020, 2, "R5 unmasked");

    // R6: dim=1, masked source ignored, then unmasked
    dim = 1; irq_unmask = '0;
    enter_idle();
    irq_pend = 32'h0000_0080;
    step(6);
    chk("R6 masked ignored", idle, 1);
    chk("R6 clk still off", cpu_clk_en, 0);
    exp_q.push_back(2);
    irq_unmask = 32'h0000_0080;
    step(1);
    chk("R6 unmask wakes", cpu_clk_en, 1);
    irq_pend = '0; irq_unmask = '0; dim = 0;
    step(3);

    // R8: watchdog beats irq
    enter_idle();
    exp_q.push_back(4);
    wdog_match = 1; irq_pend = 32'h0000_0001;
    step(3);
    chk("R8 woke", idle, 0);
    wdog_match = 0; irq_pend = '0;
    step(3);

    // R9: already pending
    irq_pend = 32'h0000_0004;
    step(3);
    exp_q.push_back(1);
    wfi_req = 1; step(1); wfi_req = 0;
    chk("R9 no idle", idle, 0);
    chk("R9 clk kept", cpu_clk_en, 1);
    chk("R9 done", wfi_done, 1);
    irq_pend = '0;
    step(3);

    // R3: on strobe ignored while idle
    enter_idle();
    clksw_on = 1; step(1); clksw_on = 0;
    chk("R3 on ignored in idle", clksw_en, 0);

    // R11: reset ends idle
    rst_n = 0; #1;
    chk("R11 clk_en on reset", cpu_clk_en, 1);
    step(1);
    rst_n = 1;
    step(1);
    chk("R11 idle cleared", idle, 0);
    chk("R11 cause reset", wake_cause, 3);
    chk("R1 clksw after reset", clksw_en, 1);

    step(2);
    chk("R7 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule